// File: doc/BRIEF.md
# Instruction Queue Line Writer

This block sits between the pre-decode stage and the instruction decoders. Each fetch line covers 16 aligned bytes. It arrives with its instruction records already extracted. A record holds a start offset, a length, a flag for a length-changing prefix and a flag that marks a branch. The block accepts one line at a time and charges a fixed extra delay for every length-changing prefix in that line. It then copies the line's records into an 18-entry circular instruction queue, at most six records per cycle. It takes no new line until the last record of the current line has been written.

On the decoder side the queue shows up to five of its oldest records at once. The decoders say how many of those they consume in each cycle. When the queue lacks room for the next group, writing pauses and the fetch side sees its ready signal held low. A flush throws away the queue contents, the line being split and any delay still owed.

Top module: `iq_writer`

## Requirements
- R1: While reset is held and in the first cycle after it, `outCount` is 0 and `lineReady` is 1.
- R2: The block writes at most 6 records per cycle. A line of k records with no length-changing prefix is written over max(1, ceil(k/6)) cycles. The next line can be accepted at the clock edge that ends the last of those cycles, provided the queue has room.
- R3: Each valid record whose `lineLcp` bit is 1 adds 3 cycles before the line's first write. With p such records, the time from one acceptance to the next is 3p + max(1, ceil(k/6)) cycles.
- R4: `lineReady` stays 0 from the acceptance of a line until the cycle in which its last record is written.
- R5: The queue holds 18 records. A group is written only when the free slots are at least the group size (min(6, records left)). Otherwise writing stalls with `lineReady` low, and no record is lost or reordered.
- R6: `outCount` equals min(occupancy, 5). Output slot 0 is the oldest record. At each clock edge, min(`decTake`, `outCount`) of the oldest records leave, and records leave in the order in which they were written.
- R7: A `flush` sampled at a clock edge leaves the queue empty and `lineReady` at 1 after that edge. The flush discards the partly written line and any pending prefix delay.
- R8: Records at index `lineCount` or above are ignored. They are never written, and their `lineLcp` bits add no delay.
- R9: Record i of a line uses bits [4i+3:4i] of `lineOffsets`, bits [5i+4:5i] of `lineLengths` and bit i of `lineLcp` and `lineBranch`. Output slot j uses the same layout in the `out*` ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue and drop the line being processed |
| lineValid | input | 1 | A fetch line is offered |
| lineReady | output | 1 | The block accepts the offered line at this edge |
| lineCount | input | 5 | Number of valid records in the line (0 to 16) |
| lineOffsets | input | 64 | Start offset of each record, 4 bits per record |
| lineLengths | input | 80 | Length of each record, 5 bits per record |
| lineLcp | input | 16 | Length-changing prefix flag per record |
| lineBranch | input | 16 | Branch flag per record |
| decTake | input | 3 | Number of shown records the decoders consume this cycle |
| outCount | output | 3 | Number of valid output slots (0 to 5) |
| outOffsets | output | 20 | Offsets of output slots, oldest in slot 0 |
| outLengths | output | 25 | Lengths of output slots |
| outLcp | output | 5 | Prefix flags of output slots |
| outBranch | output | 5 | Branch flags of output slots |

## Verification
The properties assume that `lineCount` never exceeds 16. They also assume that a line, once offered, stays offered with a stable count until `lineReady` accepts it. The bench drives each line from one edge and holds it until acceptance, and it never offers more than 16 records. A `decTake` larger than `outCount` is allowed, because the block clamps it. The bench uses larger values both to drain the queue and to show that only the shown records leave. Timing-sensitive lines are sent only into an empty queue, so that the measured acceptance gap depends on the line alone.

// File: rtl/iqw_pkg.sv
package iqw_pkg;
  localparam int OFF_W      = 4;
  localparam int LEN_W      = 5;
  localparam int LINE_SLOTS = 16;
  localparam int WR_RATE    = 6;
  localparam int RD_RATE    = 5;
  localparam int IQ_DEPTH   = 18;
  localparam int LCP_COST   = 3;

  localparam int SLOT_W = $clog2(LINE_SLOTS);
  localparam int CNT_W  = $clog2(LINE_SLOTS + 1);
  localparam int GRP_W  = $clog2(WR_RATE + 1);
  localparam int OUT_W  = $clog2(RD_RATE + 1);
  localparam int PTR_W  = $clog2(IQ_DEPTH);
  localparam int OCC_W  = $clog2(IQ_DEPTH + 1);
  localparam int PEN_W  = $clog2(LCP_COST * LINE_SLOTS + 1);

  typedef struct packed {
    logic             lcp;
    logic             br;
    logic [LEN_W-1:0] len;
    logic [OFF_W-1:0] off;
  } insnRec_t;

  typedef struct packed {
    logic             load;
    logic             flush;
    logic [GRP_W-1:0] wrCount;
    logic [CNT_W-1:0] grpBase;
  } ctlStrobe_t;
endpackage

// File: rtl/iqw_ctrl.sv
module iqw_ctrl
  import iqw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  lineValid,
  input  logic [CNT_W-1:0]      lineCount,
  input  logic [LINE_SLOTS-1:0] lineLcp,
  input  logic [OCC_W-1:0]      freeSlots,
  output logic                  lineReady,
  output ctlStrobe_t            strobes
);
  localparam logic [CNT_W-1:0] RATE_C = CNT_W'(WR_RATE);
  localparam logic [PEN_W-1:0] COST_C = PEN_W'(LCP_COST);

  logic             busy;
  logic [PEN_W-1:0] penLeft;
  logic [CNT_W-1:0] remLeft;
  logic [CNT_W-1:0] baseIdx;

  logic [CNT_W-1:0] lcpCount;
  logic [GRP_W-1:0] group;
  logic             penDone, canWrite, lastStep, load;

  // Only flags of valid records count toward the delay.
  always_comb begin
    lcpCount = '0;
    for (int i = 0; i < LINE_SLOTS; i++) begin
      if (CNT_W'(i) < lineCount && lineLcp[i]) lcpCount = lcpCount + 1'b1;
    end
  end

  assign group    = (remLeft > RATE_C) ? GRP_W'(WR_RATE) : GRP_W'(remLeft);
  assign penDone  = (penLeft == '0);
  assign canWrite = busy && penDone && (remLeft != '0) && (freeSlots >= OCC_W'(group));
  assign lastStep = busy && penDone && ((remLeft == '0) || (canWrite && remLeft <= RATE_C));
  assign lineReady = !busy || lastStep;
  assign load      = lineValid && lineReady && !flush;

  assign strobes.load    = load;
  assign strobes.flush   = flush;
  assign strobes.wrCount = canWrite ? group : '0;
  assign strobes.grpBase = baseIdx;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      busy    <= 1'b0;
      penLeft <= '0;
      remLeft <= '0;
      baseIdx <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      penLeft <= PEN_W'(lcpCount) * COST_C;
      remLeft <= lineCount;
      baseIdx <= '0;
    end else if (busy) begin
      if (!penDone) begin
        penLeft <= penLeft - 1'b1;
      end else if (lastStep) begin
        busy    <= 1'b0;
        remLeft <= '0;
      end else if (canWrite) begin
        remLeft <= remLeft - CNT_W'(group);
        baseIdx <= baseIdx + CNT_W'(group);
      end
    end
  end
endmodule

// File: rtl/iqw_datapath.sv
module iqw_datapath
  import iqw_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  ctlStrobe_t                  strobes,
  input  logic [LINE_SLOTS*OFF_W-1:0] lineOffsets,
  input  logic [LINE_SLOTS*LEN_W-1:0] lineLengths,
  input  logic [LINE_SLOTS-1:0]       lineLcp,
  input  logic [LINE_SLOTS-1:0]       lineBranch,
  input  logic [OUT_W-1:0]            decTake,
  output logic [OCC_W-1:0]            freeSlots,
  output logic [OCC_W-1:0]            occupancy,
  output logic [OUT_W-1:0]            outCount,
  output logic [RD_RATE*OFF_W-1:0]    outOffsets,
  output logic [RD_RATE*LEN_W-1:0]    outLengths,
  output logic [RD_RATE-1:0]          outLcp,
  output logic [RD_RATE-1:0]          outBranch
);
  insnRec_t lineBuf [LINE_SLOTS];
  insnRec_t queue   [IQ_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [OCC_W-1:0] occ;
  logic [OUT_W-1:0] take;

  function automatic logic [PTR_W-1:0] wrapIdx(input logic [PTR_W:0] x);
    if (x >= (PTR_W+1)'(IQ_DEPTH)) return PTR_W'(x - (PTR_W+1)'(IQ_DEPTH));
    return PTR_W'(x);
  endfunction

  assign occupancy = occ;
  assign freeSlots = OCC_W'(IQ_DEPTH) - occ;
  assign outCount  = (occ > OCC_W'(RD_RATE)) ? OUT_W'(RD_RATE) : OUT_W'(occ);
  assign take      = (decTake > outCount) ? outCount : decTake;

  always_ff @(posedge clk) begin
    if (strobes.load) begin
      for (int i = 0; i < LINE_SLOTS; i++) begin
        lineBuf[i] <= '{lcp: lineLcp[i], br: lineBranch[i],
                        len: lineLengths[i*LEN_W +: LEN_W],
                        off: lineOffsets[i*OFF_W +: OFF_W]};
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < WR_RATE; i++) begin
      if (!strobes.flush && GRP_W'(i) < strobes.wrCount &&
          (int'(strobes.grpBase) + i) < LINE_SLOTS) begin
        queue[wrapIdx({1'b0, wrPtr} + (PTR_W+1)'(i))] <=
          lineBuf[SLOT_W'(int'(strobes.grpBase) + i)];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobes.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      wrPtr <= wrapIdx({1'b0, wrPtr} + (PTR_W+1)'(strobes.wrCount));
      rdPtr <= wrapIdx({1'b0, rdPtr} + (PTR_W+1)'(take));
      occ   <= occ + OCC_W'(strobes.wrCount) - OCC_W'(take);
    end
  end

  for (genvar j = 0; j < RD_RATE; j++) begin : g_out
    insnRec_t slotRec;
    assign slotRec = queue[wrapIdx({1'b0, rdPtr} + (PTR_W+1)'(j))];
    assign outOffsets[j*OFF_W +: OFF_W] = slotRec.off;
    assign outLengths[j*LEN_W +: LEN_W] = slotRec.len;
    assign outLcp[j]    = slotRec.lcp;
    assign outBranch[j] = slotRec.br;
  end
endmodule

// File: rtl/iq_writer.sv
module iq_writer
  import iqw_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        lineValid,
  output logic                        lineReady,
  input  logic [CNT_W-1:0]            lineCount,
  input  logic [LINE_SLOTS*OFF_W-1:0] lineOffsets,
  input  logic [LINE_SLOTS*LEN_W-1:0] lineLengths,
  input  logic [LINE_SLOTS-1:0]       lineLcp,
  input  logic [LINE_SLOTS-1:0]       lineBranch,
  input  logic [OUT_W-1:0]            decTake,
  output logic [OUT_W-1:0]            outCount,
  output logic [RD_RATE*OFF_W-1:0]    outOffsets,
  output logic [RD_RATE*LEN_W-1:0]    outLengths,
  output logic [RD_RATE-1:0]          outLcp,
  output logic [RD_RATE-1:0]          outBranch
);
  ctlStrobe_t       strobes;
  logic [OCC_W-1:0] freeSlots;
  logic [OCC_W-1:0] occupancy;

  iqw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lineValid(lineValid),
    .lineCount(lineCount), .lineLcp(lineLcp), .freeSlots(freeSlots),
    .lineReady(lineReady), .strobes(strobes)
  );

  iqw_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .lineOffsets(lineOffsets), .lineLengths(lineLengths),
    .lineLcp(lineLcp), .lineBranch(lineBranch), .decTake(decTake),
    .freeSlots(freeSlots), .occupancy(occupancy), .outCount(outCount),
    .outOffsets(outOffsets), .outLengths(outLengths),
    .outLcp(outLcp), .outBranch(outBranch)
  );
endmodule

// File: rtl/iq_writer_chk.sv
module iq_writer_chk
  import iqw_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush,
  input logic                  lineValid,
  input logic                  lineReady,
  input logic [CNT_W-1:0]      lineCount,
  input logic [LINE_SLOTS-1:0] lineLcp,
  input logic [OUT_W-1:0]      outCount,
  input logic [OCC_W-1:0]      occupancy,
  input logic [GRP_W-1:0]      wrCount
);
  logic anyLcp;
  always_comb begin
    anyLcp = 1'b0;
    for (int i = 0; i < LINE_SLOTS; i++) begin
      if (CNT_W'(i) < lineCount && lineLcp[i]) anyLcp = 1'b1;
    end
  end

  // R5: never more records than queue entries
  a_r5_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occupancy) <= IQ_DEPTH);

  // R2: occupancy grows by at most the write rate per cycle
  a_r2_write_rate: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> int'(occupancy) <= int'($past(occupancy)) + WR_RATE);

  // R6: occupancy shrinks by at most the read rate per cycle
  a_r6_read_rate: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> int'(occupancy) + RD_RATE >= int'($past(occupancy)));

  // R6: a non-empty queue always shows at least one record
  a_r6_out_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy != '0) |-> (outCount != '0));

  // R7: flush leaves an empty queue and a ready line input
  a_r7_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occupancy == '0) && lineReady);

  // R3: a line with a prefix flag writes nothing in the cycle after acceptance
  a_r3_penalty_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    (lineValid && lineReady && !flush && anyLcp) |=> (wrCount == '0) && !lineReady);

  // R8: input condition, the count never exceeds the slots of a line
  a_r8_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lineCount) <= LINE_SLOTS);

  // R4: input condition, an offered line is held until accepted
  a_r4_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lineValid && !lineReady && !flush) |=> lineValid && $stable(lineCount));
endmodule

bind iq_writer iq_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lineValid(lineValid),
  .lineReady(lineReady), .lineCount(lineCount), .lineLcp(lineLcp),
  .outCount(outCount), .occupancy(occupancy), .wrCount(strobes.wrCount)
);

// File: tb/iq_writer_bench.sv
module iq_writer_bench;
  import iqw_pkg::*;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, flush, lineValid, lineReady;
  logic [CNT_W-1:0]            lineCount;
  logic [LINE_SLOTS*OFF_W-1:0] lineOffsets;
  logic [LINE_SLOTS*LEN_W-1:0] lineLengths;
  logic [LINE_SLOTS-1:0]       lineLcp, lineBranch;
  logic [OUT_W-1:0]            decTake, outCount;
  logic [RD_RATE*OFF_W-1:0]    outOffsets;
  logic [RD_RATE*LEN_W-1:0]    outLengths;
  logic [RD_RATE-1:0]          outLcp, outBranch;

  iq_writer u_iq_writer (.*);

  int checks = 0, failures = 0;
  logic [10:0] expQ [0:1023];
  int expHead = 0, expTail = 0, tagCtr = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Order and content monitor (R6, R9): sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !flush) begin
      int tk;
      tk = (int'(decTake) > int'(outCount)) ? int'(outCount) : int'(decTake);
      for (int i = 0; i < tk; i++) begin
        logic [10:0] got;
        got = {outLcp[i], outBranch[i], outLengths[i*LEN_W +: LEN_W], outOffsets[i*OFF_W +: OFF_W]};
        chk(expHead + i < expTail, "R6", "record beyond sent", expHead + i, expTail);
        chk(got == expQ[(expHead + i) % 1024], "R6 R9", "record order/content",
            int'(got), int'(expQ[(expHead + i) % 1024]));
      end
      expHead += tk;
    end
  end

  // Present a line (record i gets offset i and a running tag as length) and wait for acceptance.
  task automatic sendLine(input int k, input logic [15:0] lcpM, input logic [15:0] brM);
    for (int i = 0; i < LINE_SLOTS; i++) begin
      logic [4:0] tg;
      tg = 5'((tagCtr % 31) + 1);
      lineOffsets[i*OFF_W +: OFF_W] = 4'(i);
      lineLengths[i*LEN_W +: LEN_W] = tg;
      if (i < k) begin
        expQ[expTail % 1024] = {lcpM[i], brM[i], tg, 4'(i)};
        expTail++;
        tagCtr++;
      end
    end
    lineLcp = lcpM; lineBranch = brM; lineCount = CNT_W'(k);
    lineValid = 1'b1;
    do @(negedge clk); while (!lineReady);
    @(posedge clk); #1;
    lineValid = 1'b0;
  endtask

  // Cycles from the accepting edge until lineReady is seen high again.
  task automatic measureGap(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!lineReady && n < 300);
  endtask

  task automatic waitEmpty();
    int guard = 0;
    do begin @(negedge clk); guard++; end while ((outCount != 0 || !lineReady) && guard < 300);
  endtask

  typedef struct packed {
    logic [7:0]  k;
    logic [15:0] lcp;
    logic [15:0] br;
    logic [7:0]  gap;
    logic [7:0]  req;
  } vec_t;

  // gap = 3*(valid prefix flags) + max(1, ceil(k/6))
  localparam vec_t VECS [11] = '{
    '{8'd1,  16'h0000, 16'h0000, 8'd1, 8'd2},
    '{8'd6,  16'h0000, 16'h0021, 8'd1, 8'd2},
    '{8'd7,  16'h0000, 16'h0000, 8'd2, 8'd2},
    '{8'd12, 16'h0000, 16'h0800, 8'd2, 8'd2},
    '{8'd13, 16'h0000, 16'h0000, 8'd3, 8'd2},
    '{8'd16, 16'h0000, 16'hFFFF, 8'd3, 8'd2},
    '{8'd3,  16'h0002, 16'h0000, 8'd4, 8'd3},
    '{8'd7,  16'h0041, 16'h0004, 8'd8, 8'd3},
    '{8'd0,  16'h0000, 16'h0000, 8'd1, 8'd8},
    '{8'd2,  16'h0020, 16'h0000, 8'd1, 8'd8},
    '{8'd16, 16'h8001, 16'h0000, 8'd9, 8'd3}
  };

  function automatic string reqName(input int r);
    case (r)
      2: return "R2";
      3: return "R3 R4";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int gap;
    rst_n = 1'b0; flush = 1'b0; lineValid = 1'b0; lineCount = '0;
    lineOffsets = '0; lineLengths = '0; lineLcp = '0; lineBranch = '0; decTake = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(outCount == 0, "R1", "outCount in reset", int'(outCount), 0);
    chk(lineReady == 1'b1, "R1", "lineReady in reset", int'(lineReady), 1);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk(outCount == 0 && lineReady, "R1", "state after reset", int'(outCount), 0);

    // Table walk: each line into an empty, draining queue.
    decTake = 3'd5;
    foreach (VECS[v]) begin
      waitEmpty();
      @(posedge clk); #1;
      sendLine(int'(VECS[v].k), VECS[v].lcp, VECS[v].br);
      measureGap(gap);
      chk(gap == int'(VECS[v].gap), reqName(int'(VECS[v].req)), "acceptance gap", gap, int'(VECS[v].gap));
    end
    waitEmpty();
    chk(expHead == expTail, "R8", "all valid records delivered, none extra", expHead, expTail);

    // R5: queue full stalls the next line, nothing lost.
    @(posedge clk); #1; decTake = 3'd0;
    sendLine(16, 16'h0000, 16'h0000);
    sendLine(16, 16'h0000, 16'h00F0);
    repeat (4) @(negedge clk);
    chk(lineReady == 1'b0, "R5", "lineReady low when queue lacks room", int'(lineReady), 0);
    chk(outCount == 3'd5, "R6", "outCount capped at 5", int'(outCount), 5);
    @(posedge clk); #1; decTake = 3'd5;
    waitEmpty();
    chk(expHead == expTail, "R5", "no record dropped under stall", expHead, expTail);

    // R6: partial consumption takes the oldest records.
    @(posedge clk); #1; decTake = 3'd0;
    sendLine(4, 16'h0000, 16'h0003);
    repeat (2) @(negedge clk);
    chk(outCount == 3'd4, "R6", "outCount equals occupancy", int'(outCount), 4);
    @(posedge clk); #1; decTake = 3'd2;
    @(posedge clk); #1; decTake = 3'd0;
    @(negedge clk);
    chk(outCount == 3'd2, "R6", "two oldest consumed", int'(outCount), 2);
    @(posedge clk); #1; decTake = 3'd7;
    @(negedge clk);
    @(negedge clk);
    chk(outCount == 3'd0, "R6", "oversized take clamps to shown", int'(outCount), 0);
    chk(expHead == expTail, "R6", "consumed count", expHead, expTail);

    // R7: flush drops queue, partial line and pending delay.
    @(posedge clk); #1; decTake = 3'd0;
    sendLine(6, 16'h0000, 16'h0000);
    sendLine(3, 16'h0001, 16'h0000);
    @(posedge clk); #1; flush = 1'b1; expHead = expTail;
    @(posedge clk); #1; flush = 1'b0;
    @(negedge clk);
    chk(outCount == 3'd0, "R7", "queue empty after flush", int'(outCount), 0);
    chk(lineReady == 1'b1, "R7", "lineReady after flush", int'(lineReady), 1);
    repeat (6) @(negedge clk);
    chk(outCount == 3'd0, "R7", "discarded line never written", int'(outCount), 0);
    @(posedge clk); #1; decTake = 3'd5;
    sendLine(2, 16'h0000, 16'h0002);
    measureGap(gap);
    chk(gap == 1, "R7", "no leftover delay after flush", gap, 1);
    waitEmpty();
    chk(expHead == expTail, "R7", "post-flush line delivered", expHead, expTail);

    finishRun();
  end
endmodule